// File: doc/BRIEF.md
# Enable and PWM Dimming Shutdown Controller

This block reads a single asynchronous input that serves two purposes at once. While the input is high, the lighting path is fully enabled. A short low interval is dimming off-time. During that time the current sink and the boost stage are gated off, the compensation node is left floating, and the bias circuits stay powered so the next high interval can start at once. A low interval that lasts a whole timeout is taken as a shutdown command. All control outputs drop, a single-cycle pulse clears every latched fault elsewhere in the chip, and the next high level asks the startup check sequence to run again.

The input first passes through a two-flop synchroniser. A falling-edge detector follows, and every falling edge restarts a saturating low-time counter. The counter's length is a parameter in system clock cycles. Its default is 3,200,000, which is 16 ms at 200 MHz. A three-state machine decides the outputs. Its states are `ST_SHUTDOWN`, `ST_ON` and `ST_DIM_OFF`, and its transitions are:

- `T_WAKE`: `ST_SHUTDOWN` to `ST_ON` on a high level.
- `T_DIM`: `ST_ON` to `ST_DIM_OFF` on a low level.
- `T_RESUME`: `ST_DIM_OFF` to `ST_ON` on a high level.
- `T_TIMEOUT`: `ST_DIM_OFF` to `ST_SHUTDOWN` when the counter expires. This transition has priority over `T_RESUME`.

Top module: `pwm_enable_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with the input low, `shutdown` is 1 and `sink_on`, `boost_on`, `comp_float`, `bias_hold`, `fault_clear` and `startup_req` are 0.
- R2: A settled high input gives `sink_on`=1, `boost_on`=1, `bias_hold`=1, `comp_float`=0 and `shutdown`=0.
- R3: A low interval shorter than TIMEOUT_CYCLES clock cycles, entered from the enabled state, gives `sink_on`=0, `boost_on`=0, `comp_float`=1, `bias_hold`=1 and `shutdown`=0. A low of exactly TIMEOUT_CYCLES-1 cycles never reaches shutdown.
- R4: A low interval of at least TIMEOUT_CYCLES cycles sets `shutdown`=1 and all other level outputs to 0, on the (TIMEOUT_CYCLES+3)-th rising edge after the input falls.
- R5: `fault_clear` is a single-cycle pulse. It is raised exactly once per timed-out low interval, in the same cycle that `shutdown` rises from the dimming state.
- R6: Every output level change happens on the third rising clock edge after the input changes, in both directions.
- R7: Leaving shutdown on a high input raises `startup_req` for exactly one cycle, together with the rise of `sink_on`. Returning from dimming off-time never raises `startup_req`.
- R8: Each falling edge restarts the low-time count. Two low intervals that are each shorter than the timeout, separated by a one-cycle high, do not add up to a shutdown.
- R9: A high pulse lasting N clock cycles (N at least 1) during dimming gives `sink_on` high for exactly N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dim_en_pin | input | 1 | Asynchronous enable/dimming level; low means off |
| sink_on | output | 1 | LED current sink enable at full current |
| boost_on | output | 1 | Boost converter switching enable |
| comp_float | output | 1 | Float the compensation node (dimming off-time) |
| bias_hold | output | 1 | Keep references and critical bias powered |
| shutdown | output | 1 | Full shutdown, all current sources off |
| fault_clear | output | 1 | One-cycle pulse clearing latched faults |
| startup_req | output | 1 | One-cycle pulse requesting the startup check sequence |

## Verification
Every level output follows the input three rising edges after the input changes: two synchroniser stages plus the registered state and output stage. The bench changes the input just after a falling clock edge and reads outputs only at falling edges. It confirms that the old value still holds after the second edge and that the new value appears after the third. A timeout lands on edge TIMEOUT_CYCLES+3 after the fall, so the boundary tests hold the input low for exactly TIMEOUT_CYCLES-1 and TIMEOUT_CYCLES cycles. Both pulse outputs are counted by a falling-edge monitor, and the bench compares the running totals with the number of timeouts and wake-ups it has caused.

// File: rtl/dimctl_pkg.sv
package dimctl_pkg;

    typedef enum logic [1:0] {
        ST_SHUTDOWN = 2'd0,
        ST_ON       = 2'd1,
        ST_DIM_OFF  = 2'd2
    } dim_state_e;

endpackage

// File: rtl/dimctl_sync.sv
// Multi-stage synchroniser for the asynchronous enable/dimming input,
// followed by a falling-edge detector on the synchronised level.
module dimctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign fall  = prev_q & ~level;

    // R8: a falling edge is reported for one cycle only
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/dimctl_low_timer.sv
// Saturating low-time counter. It restarts on each falling edge and raises
// a registered expiry pulse once the low level has lasted TIMEOUT_CYCLES.
module dimctl_low_timer #(
    parameter int TIMEOUT_CYCLES = 3200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic fall,
    output logic expire
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] TERM     = CNT_W'(TIMEOUT_CYCLES);
    localparam logic [CNT_W-1:0] TERM_M1  = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             expire_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (level) begin
            cnt_q <= '0;
        end else if (fall) begin
            cnt_q <= CNT_W'(1);
        end else if (cnt_q != TERM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) expire_q <= 1'b0;
        else        expire_q <= !level && (cnt_q == TERM_M1);
    end

    assign expire = expire_q;

    // R4: the counter stops at its terminal count
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TERM);

    // R5: expiry is a single pulse per low interval
    expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    // R8: a falling edge always restarts the count near zero
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (cnt_q == CNT_W'(1)) || level);

endmodule

// File: rtl/dimctl_fsm.sv
// Mode state machine: enabled, dimming off-time and shutdown.
module dimctl_fsm
    import dimctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic expire,
    output logic sink_on,
    output logic boost_on,
    output logic comp_float,
    output logic bias_hold,
    output logic shutdown,
    output logic fault_clear,
    output logic startup_req
);
    dim_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHUTDOWN;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHUTDOWN: if (level)  state_d = ST_ON;        // T_WAKE
            ST_ON:       if (!level) state_d = ST_DIM_OFF;   // T_DIM
            ST_DIM_OFF: begin
                if (expire)     state_d = ST_SHUTDOWN;       // T_TIMEOUT
                else if (level) state_d = ST_ON;             // T_RESUME
            end
            default:     state_d = ST_SHUTDOWN;
        endcase
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sink_on     <= 1'b0;
            boost_on    <= 1'b0;
            comp_float  <= 1'b0;
            bias_hold   <= 1'b0;
            shutdown    <= 1'b1;
            fault_clear <= 1'b0;
            startup_req <= 1'b0;
        end else begin
            sink_on     <= (state_d == ST_ON);
            boost_on    <= (state_d == ST_ON);
            comp_float  <= (state_d == ST_DIM_OFF);
            bias_hold   <= (state_d != ST_SHUTDOWN);
            shutdown    <= (state_d == ST_SHUTDOWN);
            fault_clear <= (state_q == ST_DIM_OFF) && (state_d == ST_SHUTDOWN);
            startup_req <= (state_q == ST_SHUTDOWN) && (state_d == ST_ON);
        end
    end

    // R5
    fault_clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clear |=> !fault_clear);

    // R5
    clear_with_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clear |-> shutdown && $past(comp_float));

    // R7
    startup_after_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        startup_req |-> sink_on && $past(shutdown));

    // R7
    no_startup_on_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_on && $past(comp_float)) |-> !startup_req);

    // R3
    dim_keeps_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(comp_float) |-> $past(sink_on) && bias_hold);

endmodule

// File: rtl/pwm_enable_ctrl.sv
module pwm_enable_ctrl #(
    parameter int TIMEOUT_CYCLES = 3200000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dim_en_pin,
    output logic sink_on,
    output logic boost_on,
    output logic comp_float,
    output logic bias_hold,
    output logic shutdown,
    output logic fault_clear,
    output logic startup_req
);
    logic lvl_s;
    logic fall_s;
    logic expire_s;

    dimctl_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (dim_en_pin),
        .level (lvl_s),
        .fall  (fall_s)
    );

    dimctl_low_timer #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (lvl_s),
        .fall   (fall_s),
        .expire (expire_s)
    );

    dimctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (lvl_s),
        .expire      (expire_s),
        .sink_on     (sink_on),
        .boost_on    (boost_on),
        .comp_float  (comp_float),
        .bias_hold   (bias_hold),
        .shutdown    (shutdown),
        .fault_clear (fault_clear),
        .startup_req (startup_req)
    );

    // R6: the sink only turns on after the synchronised level was high
    sink_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sink_on) |-> $past(lvl_s));

endmodule

// File: tb/sim_pwm_enable_ctrl.sv
module sim_pwm_enable_ctrl;
    localparam int T = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 1'b0;
    logic sink_on, boost_on, comp_float, bias_hold, shutdown, fault_clear, startup_req;

    int checks = 0;
    int errors = 0;
    int fc_cnt = 0;
    int su_cnt = 0;
    int sink_cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_enable_ctrl #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .dim_en_pin(pin),
        .sink_on(sink_on), .boost_on(boost_on), .comp_float(comp_float),
        .bias_hold(bias_hold), .shutdown(shutdown),
        .fault_clear(fault_clear), .startup_req(startup_req)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (fault_clear) fc_cnt++;
            if (startup_req) su_cnt++;
            if (sink_on)     sink_cyc++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_mode(input string tag, input int s, input int cf, input int sh);
        chk({tag, " sink_on"},    int'(sink_on),    s);
        chk({tag, " boost_on"},   int'(boost_on),   s);
        chk({tag, " comp_float"}, int'(comp_float), cf);
        chk({tag, " bias_hold"},  int'(bias_hold),  (sh != 0) ? 0 : 1);
        chk({tag, " shutdown"},   int'(shutdown),   sh);
    endtask

    // {level, hold[5:0], exp sink, exp comp_float, exp shutdown}
    localparam bit [9:0] VEC [7] = '{
        {1'b1, 6'd8,  3'b100},
        {1'b0, 6'd10, 3'b010},
        {1'b1, 6'd5,  3'b100},
        {1'b0, 6'd40, 3'b001},
        {1'b1, 6'd6,  3'b100},
        {1'b0, 6'd31, 3'b010},
        {1'b1, 6'd4,  3'b100}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int fc0, su0, sc0;
        // R1: reset state
        wait_n(3);
        chk_mode("R1 in reset", 0, 0, 1);
        chk("R1 fault_clear", int'(fault_clear), 0);
        chk("R1 startup_req", int'(startup_req), 0);
        rst_n = 1'b1;
        wait_n(T + 10);
        chk_mode("R1 after release", 0, 0, 1);
        chk("R1 no clear pulse", fc_cnt, 0);

        // Vector table: R2, R3, R4
        foreach (VEC[i]) begin
            pin = VEC[i][9];
            wait_n(int'(VEC[i][8:3]));
            chk_mode($sformatf("R2/R3/R4 vec%0d", i),
                     int'(VEC[i][2]), int'(VEC[i][1]), int'(VEC[i][0]));
        end
        // R5, R7: one timeout, two wake-ups so far
        chk("R5 clear pulses", fc_cnt, 1);
        chk("R7 startup pulses", su_cnt, 2);

        // R6: three-edge latency, falling then rising; R7 no startup on resume
        pin = 1'b0;
        wait_n(2);
        chk("R6 fall edge2 sink", int'(sink_on), 1);
        wait_n(1);
        chk("R6 fall edge3 sink", int'(sink_on), 0);
        wait_n(5);
        pin = 1'b1;
        wait_n(2);
        chk("R6 rise edge2 sink", int'(sink_on), 0);
        wait_n(1);
        chk("R6 rise edge3 sink", int'(sink_on), 1);
        chk("R7 resume no startup", int'(startup_req), 0);
        wait_n(4);

        // R4/R5 boundary: low for exactly T cycles
        fc0 = fc_cnt; su0 = su_cnt;
        pin = 1'b0;
        wait_n(T + 2);
        chk("R4 edge T+2 shutdown", int'(shutdown), 0);
        wait_n(1);
        chk("R4 edge T+3 shutdown", int'(shutdown), 1);
        chk("R5 pulse with shutdown", int'(fault_clear), 1);
        wait_n(1);
        chk("R5 pulse width", int'(fault_clear), 0);
        pin = 1'b1;
        wait_n(3);
        chk("R7 startup with sink", int'(startup_req) + int'(sink_on), 2);
        wait_n(1);
        chk("R7 startup width", int'(startup_req), 0);
        chk("R5 one clear", fc_cnt - fc0, 1);

        // R3 boundary: low for exactly T-1 cycles then high
        fc0 = fc_cnt;
        pin = 1'b0;
        wait_n(T - 1);
        pin = 1'b1;
        wait_n(8);
        chk("R3 T-1 no clear", fc_cnt - fc0, 0);
        chk_mode("R3 T-1 resumed", 1, 0, 0);

        // R8: two short lows separated by one-cycle high
        fc0 = fc_cnt; su0 = su_cnt;
        pin = 1'b0;
        wait_n(T - 8);
        pin = 1'b1;
        wait_n(1);
        pin = 1'b0;
        wait_n(T - 8);
        chk_mode("R8 still dimming", 0, 1, 0);
        chk("R8 no clear", fc_cnt - fc0, 0);

        // R9: one-cycle and three-cycle high pulses during dimming
        sc0 = sink_cyc;
        pin = 1'b1;
        wait_n(1);
        pin = 1'b0;
        wait_n(8);
        chk("R9 one-cycle pulse", sink_cyc - sc0, 1);
        sc0 = sink_cyc;
        pin = 1'b1;
        wait_n(3);
        pin = 1'b0;
        wait_n(8);
        chk("R9 three-cycle pulse", sink_cyc - sc0, 3);
        chk("R7 no startup from dim", su_cnt - su0, 0);

        // R1: reset mid-operation
        pin = 1'b1;
        wait_n(6);
        rst_n = 1'b0;
        wait_n(1);
        chk_mode("R1 mid reset", 0, 0, 1);
        pin = 1'b0;
        rst_n = 1'b1;
        wait_n(4);
        chk_mode("R1 after mid reset", 0, 0, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule